// File: doc/BRIEF.md
# Microsecond Down-Count Event Timer

This block is a programmable event timer that advances on a one-microsecond tick strobe supplied by a shared time base. Software controls it through a 32-bit register window with two words. The first word, called the load word, arms the timer. It carries a run flag, a repeat flag and a count, all in one write. The second word, called the acknowledge word, reports and clears the pending event. The count written is the wanted interval minus one, so a count of N raises the event on the (N+1)th tick after the write.

In one-shot use the timer runs down once, asserts its level interrupt and disarms itself. In repeat use it reloads the programmed count and keeps running. The interrupt stays high until software writes the acknowledge bit. A new load write replaces the running state at once. The window's base address is a parameter, so several copies can sit side by side on a shared bus.

Top module: `tick_timer`

## Requirements
- R1: After reset the interrupt is low and both register words read as zero.
- R2: A write to the load word (offset 0x0) takes bit 31 as the run flag, bit 30 as the repeat flag and bits 28:0 as the count. A read of the load word returns the run flag in bit 31, the repeat flag in bit 30, zero in bit 29 and the current count in bits 28:0.
- R3: While the timer runs, each cycle with the tick strobe high lowers the count by one if it is above zero. Without a tick, and while the timer is stopped, the count holds.
- R4: A tick that finds a running timer at count zero sets the interrupt, so a count of N gives an event on the (N+1)th tick.
- R5: In repeat mode, expiry reloads the programmed count and the timer keeps running.
- R6: In one-shot mode, expiry clears the run flag and the count stays at zero.
- R7: Writing zero to the load word stops the timer, and no later tick raises the interrupt.
- R8: A load write restarts the timer with the new count in the next cycle, even while it is running. A tick in the same cycle as the write is not applied.
- R9: The interrupt is a level that stays high until a write to the acknowledge word (offset 0x4) has bit 30 set. A write there with bit 30 clear has no effect. A read of the acknowledge word shows the pending state in bit 30.
- R10: If an expiry and an acknowledge fall in the same cycle, the interrupt stays set.
- R11: Writes to addresses other than the two words change nothing, and reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe, once per microsecond |
| bus_wr_i | input | 1 | Write strobe for the register window |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The bench aims at the off-by-one in the interval. A design that loaded the count without the minus-one convention would fire one tick early or late, and the bench counts ticks exactly. It also covers a load write that lands on a tick: a design that let the tick through would read back one below the new count. An acknowledge that coincides with a repeat-mode expiry is checked too, since a design giving the clear priority would lose that event. Finally, acknowledge writes with bit 30 clear and writes to unmapped addresses must leave the interrupt and the count untouched.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int WORD_W   = 32;
    localparam int RUN_BIT  = 31;
    localparam int RPT_BIT  = 30;
    localparam int ACK_BIT  = 30;
    localparam int ACK_OFFS = 4;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LOAD = 2'd1,
        SEL_ACK  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/tick_timer_decode.sv
module tick_timer_decode
    import tick_timer_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    localparam logic [ADDR_W-1:0] LOAD_ADDR = BASE_ADDR;
    localparam logic [ADDR_W-1:0] ACK_ADDR  = BASE_ADDR + ADDR_W'(ACK_OFFS);

    always_comb begin
        if (addr_i == LOAD_ADDR) begin
            sel_o = SEL_LOAD;
        end else if (addr_i == ACK_ADDR) begin
            sel_o = SEL_ACK;
        end else begin
            sel_o = SEL_NONE;
        end
    end

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic             load_run_i,
    input  logic             load_rpt_i,
    input  logic [CNT_W-1:0] load_cnt_i,
    input  logic             ack_i,
    output logic             run_o,
    output logic             rpt_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             irq_o
);

    typedef struct packed {
        logic             run;
        logic             rpt;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       expire;

    always_comb begin
        st_d   = st_q;
        expire = st_q.run && tick_i && (st_q.cnt == '0) && !load_i;

        if (load_i) begin
            st_d.run    = load_run_i;
            st_d.rpt    = load_rpt_i;
            st_d.reload = load_cnt_i;
            st_d.cnt    = load_cnt_i;
        end else if (st_q.run && tick_i) begin
            if (st_q.cnt == '0) begin
                if (st_q.rpt) begin
                    st_d.cnt = st_q.reload;
                end else begin
                    st_d.run = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end

        if (expire) begin
            st_d.irq = 1'b1;
        end else if (ack_i) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o    = st_q.run;
    assign rpt_o    = st_q.rpt;
    assign cnt_o    = st_q.cnt;
    assign reload_o = st_q.reload;
    assign irq_o    = st_q.irq;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter int                CNT_W     = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    reg_sel_e         sel;
    logic             load_wr;
    logic             ack_wr;
    logic             run_w;
    logic             rpt_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] reload_w;
    logic             unused_wbits;

    tick_timer_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr_i (bus_addr_i),
        .sel_o  (sel)
    );

    assign load_wr      = bus_wr_i && (sel == SEL_LOAD);
    assign ack_wr       = bus_wr_i && (sel == SEL_ACK) && bus_wdata_i[ACK_BIT];
    assign unused_wbits = ^bus_wdata_i[RPT_BIT-1:CNT_W];

    tick_timer_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_i     (load_wr),
        .load_run_i (bus_wdata_i[RUN_BIT]),
        .load_rpt_i (bus_wdata_i[RPT_BIT]),
        .load_cnt_i (bus_wdata_i[CNT_W-1:0]),
        .ack_i      (ack_wr),
        .run_o      (run_w),
        .rpt_o      (rpt_w),
        .cnt_o      (cnt_w),
        .reload_o   (reload_w),
        .irq_o      (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (sel)
            SEL_LOAD: begin
                bus_rdata_o[RUN_BIT]     = run_w;
                bus_rdata_o[RPT_BIT]     = rpt_w;
                bus_rdata_o[CNT_W-1:0]   = cnt_w;
            end
            SEL_ACK: begin
                bus_rdata_o[ACK_BIT]     = irq_o;
            end
            default: begin
                bus_rdata_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 29
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             load_wr,
    input logic             ack_wr,
    input logic             run,
    input logic             rpt,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             irq
);

    // R3
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_wr) |=> $stable(cnt));

    // R4
    irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick));

    // R5
    repeat_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && rpt && tick && cnt == '0 && !load_wr) |=> (run && cnt == reload && irq));

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !rpt && tick && cnt == '0 && !load_wr) |=> (!run && irq));

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_wr) |=> irq);

    // R7
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_wr) |=> ($stable(cnt) && !$rose(irq)));

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_i),
    .load_wr (load_wr),
    .ack_wr  (ack_wr),
    .run     (run_w),
    .rpt     (rpt_w),
    .cnt     (cnt_w),
    .reload  (reload_w),
    .irq     (irq_o)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

    localparam int          ADDR_W = 12;
    localparam logic [11:0] BASE   = 12'h050;
    localparam logic [11:0] ACKA   = 12'h054;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [11:0] bus_addr_i = BASE;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    string cur_req = "R1";

    // reference model state
    bit        m_run, m_rpt, m_irq;
    bit [28:0] m_reload, m_cnt;

    always #4 clk = ~clk;

    tick_timer #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .CNT_W(29)) u_tick_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o)
    );

    function automatic bit [31:0] exp_rdata(input bit [11:0] a);
        if (a == BASE) return {m_run, m_rpt, 1'b0, m_cnt};
        if (a == ACKA) return {1'b0, m_irq, 30'd0};
        return 32'd0;
    endfunction

    task automatic model_step(input bit wr, input bit [11:0] a, input bit [31:0] d, input bit tk);
        bit load, ack, expire;
        load   = wr && (a == BASE);
        ack    = wr && (a == ACKA) && d[30];
        expire = m_run && tk && (m_cnt == 0) && !load;
        if (load) begin
            m_run = d[31]; m_rpt = d[30]; m_reload = d[28:0]; m_cnt = d[28:0];
        end else if (m_run && tk) begin
            if (m_cnt == 0) begin
                if (m_rpt) m_cnt = m_reload;
                else       m_run = 1'b0;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
        if (expire)   m_irq = 1'b1;
        else if (ack) m_irq = 1'b0;
    endtask

    task automatic check_outputs();
        bit [31:0] er;
        er = exp_rdata(bus_addr_i);
        checks++;
        if (irq_o !== m_irq) begin
            errors++;
            $display("FAIL %s: irq actual %0b expected %0b", cur_req, irq_o, m_irq);
        end
        checks++;
        if (bus_rdata_o !== er) begin
            errors++;
            $display("FAIL %s: rdata @%h actual %h expected %h", cur_req, bus_addr_i, bus_rdata_o, er);
        end
    endtask

    // called at a negedge; applies inputs for one cycle then checks
    task automatic cyc(input bit wr, input bit [11:0] a, input bit [31:0] d, input bit tk);
        bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = d; tick_i = tk;
        @(posedge clk);
        model_step(wr, a, d, tk);
        @(negedge clk);
        check_outputs();
    endtask

    task automatic idle_read(input bit [11:0] a, input bit tk);
        cyc(1'b0, a, 32'h0, tk);
    endtask

    initial begin
        bit [11:0] a;
        bit [31:0] d;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1";
        @(negedge clk);
        check_outputs();
        idle_read(ACKA, 1'b0);

        // R2, R3, R4, R6: one-shot count 3, ticks with gaps
        cur_req = "R2";
        cyc(1'b1, BASE, 32'hA000_0003, 1'b0); // bit29 set must read back 0
        cur_req = "R3";
        for (int i = 0; i < 3; i++) begin
            idle_read(BASE, 1'b1);
            idle_read(BASE, 1'b0);
        end
        cur_req = "R4";
        idle_read(BASE, 1'b1); // fourth tick expires
        cur_req = "R6";
        repeat (4) idle_read(BASE, 1'b1);

        // R9: level held, ack without bit 30 ignored, ack with bit 30 clears
        cur_req = "R9";
        cyc(1'b1, ACKA, 32'hBFFF_FFFF, 1'b0);
        idle_read(ACKA, 1'b0);
        cyc(1'b1, ACKA, 32'h4000_0000, 1'b0);
        idle_read(ACKA, 1'b0);

        // R5, R10: repeat mode count 2
        cur_req = "R5";
        cyc(1'b1, BASE, 32'hC000_0002, 1'b0);
        repeat (3) idle_read(BASE, 1'b1);
        cyc(1'b1, ACKA, 32'h4000_0000, 1'b1);
        idle_read(BASE, 1'b1);
        cur_req = "R10";
        cyc(1'b1, ACKA, 32'h4000_0000, 1'b1); // expiry coincides with ack
        idle_read(ACKA, 1'b0);
        cyc(1'b1, ACKA, 32'h4000_0000, 1'b0);

        // R7: write zero stops
        cur_req = "R7";
        cyc(1'b1, BASE, 32'h0, 1'b0);
        repeat (5) idle_read(ACKA, 1'b1);
        idle_read(BASE, 1'b0);

        // R8: restart while running, write on a tick
        cur_req = "R8";
        cyc(1'b1, BASE, 32'h8000_0010, 1'b0);
        repeat (3) idle_read(BASE, 1'b1);
        cyc(1'b1, BASE, 32'h8000_0005, 1'b1);
        repeat (6) idle_read(BASE, 1'b1);
        cyc(1'b1, ACKA, 32'h4000_0000, 1'b0);

        // R11: unmapped writes and reads
        cur_req = "R11";
        cyc(1'b1, BASE, 32'h8000_0007, 1'b0);
        cyc(1'b1, 12'h058, 32'hFFFF_FFFF, 1'b0);
        cyc(1'b1, 12'h04C, 32'h0000_0000, 1'b0);
        cyc(1'b1, 12'h000, 32'h4000_0000, 1'b0);
        idle_read(12'h058, 1'b0);
        idle_read(BASE, 1'b0);

        // random mix, R2 R3 R4 R5 R6 R8 R9 R10 R11
        cur_req = "R8 random";
        for (int i = 0; i < 4000; i++) begin
            case ($urandom_range(0, 9))
                0, 1:    a = BASE;
                2, 3:    a = ACKA;
                4:       a = 12'($urandom);
                default: a = ($urandom_range(0, 1) != 0) ? BASE : ACKA;
            endcase
            d = $urandom;
            if ($urandom_range(0, 3) != 0) d[28:0] = 29'($urandom_range(0, 6));
            cyc(($urandom_range(0, 7) == 0), a, d, ($urandom_range(0, 2) != 0));
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule